// File: doc/BRIEF.md
# Retrigger-Guarded Fixed-Width Pulse Generator

This block turns trigger events into output pulses of a fixed number of clock cycles. After each pulse starts, a guard window of `DUTY_DIV * PULSE_W` cycles begins. Triggers inside that window do not start a pulse; each one raises a one-cycle error strobe instead. This caps the output duty cycle at 1/`DUTY_DIV`.

Two trigger paths are chosen by an active-low filter-enable input. With the filter disabled (`filt_en_n` high), the raw trigger drives the output through logic only, so the pulse appears in the same cycle the trigger rises. With the filter enabled (`filt_en_n` low), the pulse starts from a pre-synchronised rising-edge strobe. That strobe must survive a qualification window with no falling-edge strobe before the pulse is issued. The total latency is `FILT_LEN + 5` clock edges. The block also gives one-cycle strobes that mark the start and the end of each output pulse.

Top module: `retrig_pulse_gen`

## Requirements
- R1: While `rst_n` is low, all outputs are low. After reset is released, no guard window is pending: the first trigger is accepted at once.
- R2: Direct path (`filt_en_n`=1, `en`=1, block idle). In the cycle where `trig_a` rises, having been sampled low at the previous edge, `pulse_o` is already high. The first clock edge that samples `trig_a` high is the start edge s.
- R3: `pulse_o` stays high through edge s+PULSE_W-1 and is low after edge s+PULSE_W, whatever the trigger does meanwhile.
- R4: Filtered path (`filt_en_n`=0). A `trig_rise_p` sampled at edge k, with the block idle, makes edge k+FILT_LEN+5 the start edge. `pulse_o` rises after that edge and lasts PULSE_W cycles.
- R5: Filtered path. A `trig_fall_p` sampled at any edge from k+1 to k+FILT_LEN+4 cancels the pending pulse, and no error is raised. A falling strobe sampled later has no effect.
- R6: After a start at edge s, a trigger arrival is accepted again at edge s+DUTY_DIV*PULSE_W at the earliest.
- R7: A trigger arrival sampled at any edge from s+1 to s+DUTY_DIV*PULSE_W-1 starts no pulse and makes `err_p` high for exactly the following cycle. On the direct path, an arrival is `trig_a` sampled high after being sampled low. On the filtered path, an arrival is `trig_rise_p` sampled high.
- R8: `pulse_rise_p` is high for the one cycle after the start edge. `pulse_fall_p` is high for the first cycle in which the pulse has ended.
- R9: While `en` is low, no pulse starts and `err_p` stays low. A filtered qualification in progress is dropped.
- R10: `pulse_rise_p` and `pulse_fall_p` are never high for two cycles in a row.
- R11: Direct path. A trigger held high starts only one pulse, however long it is held. It must be sampled low before it can start another.
- R12: On the direct path, the edge-strobe inputs are ignored. On the filtered path, the level of `trig_a` has no direct effect on `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables pulse generation when high |
| filt_en_n | input | 1 | 0 selects the filtered strobe path, 1 selects the direct path |
| trig_a | input | 1 | Raw trigger level |
| trig_rise_p | input | 1 | One-cycle strobe on a synchronised trigger rising edge |
| trig_fall_p | input | 1 | One-cycle strobe on a synchronised trigger falling edge |
| pulse_o | output | 1 | Fixed-width output pulse, active high |
| pulse_rise_p | output | 1 | One-cycle strobe at the start of the output pulse |
| pulse_fall_p | output | 1 | One-cycle strobe at the end of the output pulse |
| err_p | output | 1 | One-cycle strobe for each trigger rejected by the guard window |

## Verification
The hardest situations to reach are the last edge of the guard window and the edge just after it, on both trigger paths. A trigger at edge s+DUTY_DIV*PULSE_W-1 must be rejected, and one a single edge later must be accepted. The stimulus counts cycles from a known start edge and places a re-armed direct trigger, or a bare rising strobe, on exactly those edges. The qualification boundary is reached the same way: a falling strobe goes on the last cancelling edge, and another goes on the first edge after the pulse has been issued.

// File: rtl/rpg_pkg.sv
`timescale 1ns/1ps
package rpg_pkg;

   typedef enum logic {
      TRIG_FILTERED = 1'b0,
      TRIG_DIRECT   = 1'b1
   } trig_path_e;

   // full period, pulse plus guard, in clock cycles
   function automatic int unsigned guard_cycles(int unsigned width, int unsigned div);
      return width * div;
   endfunction

   // edges between an accepted rising strobe and the start edge
   function automatic int unsigned qual_cycles(int unsigned filt_len);
      return filt_len + 5;
   endfunction

endpackage

// File: rtl/rpg_period_core.sv
`timescale 1ns/1ps
module rpg_period_core #(
   parameter int unsigned PULSE_W  = 24,
   parameter int unsigned DUTY_DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic idle_o,
   output logic pulse_o,
   output logic rise_p_o,
   output logic fall_p_o
);
   localparam int unsigned PERIOD = rpg_pkg::guard_cycles(PULSE_W, DUTY_DIV);
   localparam int unsigned CW     = $clog2(PERIOD);
   localparam logic [CW-1:0] LOAD_V = CW'(PERIOD - 1);
   localparam logic [CW-1:0] HIGH_V = CW'(PERIOD - PULSE_W);

   if (PULSE_W < 2 || PULSE_W > 40) begin : g_bad_width
      $error("rpg_period_core: PULSE_W must lie in 2..40");
   end
   if (DUTY_DIV < 2) begin : g_bad_div
      $error("rpg_period_core: DUTY_DIV must be at least 2");
   end

   logic          running;
   logic [CW-1:0] remain;
   logic          take;

   assign idle_o  = !running || (remain == '0);
   assign take    = start_i && idle_o;
   assign pulse_o = running && (remain >= HIGH_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         remain   <= '0;
         rise_p_o <= 1'b0;
         fall_p_o <= 1'b0;
      end else begin
         rise_p_o <= 1'b0;
         fall_p_o <= 1'b0;
         if (take) begin
            running  <= 1'b1;
            remain   <= LOAD_V;
            rise_p_o <= 1'b1;
         end else if (running) begin
            if (remain == '0) begin
               running <= 1'b0;
            end else begin
               remain <= remain - 1'b1;
            end
            if (remain == HIGH_V) begin
               fall_p_o <= 1'b1;
            end
         end
      end
   end

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_p_o |=> !rise_p_o); // R10
   AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_p_o |=> !fall_p_o); // R10
   AST_RISE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_p_o |-> pulse_o); // R8
   AST_FALL_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_p_o |-> (!pulse_o && $past(pulse_o))); // R8

endmodule

// File: rtl/rpg_direct_path.sv
`timescale 1ns/1ps
module rpg_direct_path (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic sel_i,
   input  logic trig_i,
   input  logic idle_i,
   output logic start_o,
   output logic reject_o
);
   logic trig_q;   // last sampled level; reset high so a stuck trigger is not armed
   logic arrive;

   assign arrive   = en_i && sel_i && trig_i && !trig_q;
   assign start_o  = arrive && idle_i;
   assign reject_o = arrive && !idle_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b1;
      end else begin
         trig_q <= trig_i;
      end
   end

   AST_DIRECT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o); // R11
   AST_DIRECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && reject_o)); // R7

endmodule

// File: rtl/rpg_qualifier.sv
`timescale 1ns/1ps
module rpg_qualifier #(
   parameter int unsigned FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic sel_i,
   input  logic rise_i,
   input  logic fall_i,
   input  logic idle_i,
   output logic fire_o,
   output logic reject_o
);
   localparam int unsigned LAT = rpg_pkg::qual_cycles(FILT_LEN);
   localparam int unsigned QW  = $clog2(LAT);
   localparam logic [QW-1:0] LAST_V = QW'(LAT - 2);

   logic          qbusy;
   logic [QW-1:0] qcnt;
   logic          live;
   logic          accept;

   assign live     = en_i && sel_i;
   assign accept   = live && rise_i && idle_i && !fire_o && !qbusy;
   assign reject_o = live && rise_i && (!idle_i || fire_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qbusy  <= 1'b0;
         qcnt   <= '0;
         fire_o <= 1'b0;
      end else if (!live) begin
         qbusy  <= 1'b0;
         qcnt   <= '0;
         fire_o <= 1'b0;
      end else begin
         fire_o <= 1'b0;
         if (qbusy) begin
            if (fall_i) begin
               qbusy <= 1'b0;
            end else if (qcnt == LAST_V) begin
               qbusy  <= 1'b0;
               fire_o <= 1'b1;
            end else begin
               qcnt <= qcnt + 1'b1;
            end
         end else if (accept) begin
            qbusy <= 1'b1;
            qcnt  <= '0;
         end
      end
   end

   AST_FIRE_INTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> idle_i); // R6
   AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o); // R4

endmodule

// File: rtl/retrig_pulse_gen.sv
`timescale 1ns/1ps
module retrig_pulse_gen #(
   parameter int unsigned PULSE_W  = 24,
   parameter int unsigned DUTY_DIV = 5,
   parameter int unsigned FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic filt_en_n,
   input  logic trig_a,
   input  logic trig_rise_p,
   input  logic trig_fall_p,
   output logic pulse_o,
   output logic pulse_rise_p,
   output logic pulse_fall_p,
   output logic err_p
);
   import rpg_pkg::*;

   if (PULSE_W < 2 || PULSE_W > 40) begin : g_chk_width
      $error("retrig_pulse_gen: PULSE_W out of range 2..40");
   end
   if (DUTY_DIV < 2) begin : g_chk_div
      $error("retrig_pulse_gen: DUTY_DIV below 2");
   end

   trig_path_e path;
   logic use_direct, use_filt;
   logic core_idle, core_pulse;
   logic dir_start, dir_reject;
   logic q_fire, q_reject;
   logic start;

   assign path       = trig_path_e'(filt_en_n);
   assign use_direct = (path == TRIG_DIRECT);
   assign use_filt   = (path == TRIG_FILTERED);

   rpg_direct_path u_direct (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en),
      .sel_i    (use_direct),
      .trig_i   (trig_a),
      .idle_i   (core_idle),
      .start_o  (dir_start),
      .reject_o (dir_reject)
   );

   rpg_qualifier #(.FILT_LEN(FILT_LEN)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en),
      .sel_i    (use_filt),
      .rise_i   (trig_rise_p),
      .fall_i   (trig_fall_p),
      .idle_i   (core_idle),
      .fire_o   (q_fire),
      .reject_o (q_reject)
   );

   assign start = en && (dir_start || q_fire);

   rpg_period_core #(.PULSE_W(PULSE_W), .DUTY_DIV(DUTY_DIV)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .idle_o   (core_idle),
      .pulse_o  (core_pulse),
      .rise_p_o (pulse_rise_p),
      .fall_p_o (pulse_fall_p)
   );

   // direct path adds the same-cycle head before the clocked pulse takes over
   assign pulse_o = core_pulse || dir_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_p <= 1'b0;
      end else begin
         err_p <= dir_reject || q_reject;
      end
   end

   AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      err_p |-> !pulse_rise_p); // R7
   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_rise_p |-> $past(en)); // R9
   AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      err_p |-> $past(en)); // R9

endmodule

// File: tb/test_retrig_pulse_gen.sv
`timescale 1ns/1ps
module test_retrig_pulse_gen;
   localparam int PW   = 6;
   localparam int DIV  = 3;
   localparam int FL   = 2;
   localparam int PER  = PW * DIV;
   localparam int LAT  = FL + 5;

   localparam int K_PUP = 0;
   localparam int K_PDN = 1;
   localparam int K_RS  = 2;
   localparam int K_FS  = 3;
   localparam int K_ERR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1;
   logic filt_en_n = 1'b1;
   logic trig_a = 1'b0;
   logic trig_rise_p = 1'b0;
   logic trig_fall_p = 1'b0;
   logic pulse_o, pulse_rise_p, pulse_fall_p, err_p;

   retrig_pulse_gen #(.PULSE_W(PW), .DUTY_DIV(DIV), .FILT_LEN(FL)) i_retrig_pulse_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .filt_en_n(filt_en_n),
      .trig_a(trig_a), .trig_rise_p(trig_rise_p), .trig_fall_p(trig_fall_p),
      .pulse_o(pulse_o), .pulse_rise_p(pulse_rise_p),
      .pulse_fall_p(pulse_fall_p), .err_p(err_p)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc = cyc + 1;

   typedef struct { int at; int kind; string req; } ev_t;
   ev_t exq[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit prev_p = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   task automatic expect_ev(int at, int kind, string req);
      exq.push_back('{at, kind, req});
   endtask

   task automatic expect_pulse(int s, int head, string req);
      expect_ev(s - head, K_PUP, req);
      expect_ev(s, K_RS, "R8");
      expect_ev(s + PW, K_PDN, "R3");
      expect_ev(s + PW, K_FS, "R8");
   endtask

   task automatic observe(bit hit, int kind);
      int idx;
      if (!hit) return;
      idx = -1;
      foreach (exq[i]) if (idx < 0 && exq[i].kind == kind && exq[i].at == cyc) idx = i;
      if (idx >= 0) begin
         chk(1'b1, exq[idx].req, "event", cyc, exq[idx].at);
         exq.delete(idx);
      end else begin
         chk(1'b0, "R7/R9/R12", $sformatf("unexpected event kind %0d", kind), cyc, -1);
      end
   endtask

   // monitor: samples 1 ns after the falling edge
   always begin
      @(negedge clk);
      #1;
      if (!rst_n) begin
         prev_p = 1'b0;
      end else begin
         observe(pulse_o && !prev_p, K_PUP);
         observe(!pulse_o && prev_p, K_PDN);
         observe(pulse_rise_p, K_RS);
         observe(pulse_fall_p, K_FS);
         observe(err_p, K_ERR);
         prev_p = pulse_o;
         for (int i = exq.size() - 1; i >= 0; i--) begin
            if (exq[i].at < cyc) begin
               chk(1'b0, exq[i].req, $sformatf("missing event kind %0d", exq[i].kind), -1, exq[i].at);
               exq.delete(i);
            end
         end
      end
   end

   task automatic goto_cyc(int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic tset(int e, bit v);
      goto_cyc(e - 1);
      trig_a = v;
   endtask

   task automatic rs_at(int e);
      goto_cyc(e - 1);
      trig_rise_p = 1'b1;
      @(negedge clk);
      trig_rise_p = 1'b0;
   endtask

   task automatic fs_at(int e);
      goto_cyc(e - 1);
      trig_fall_p = 1'b1;
      @(negedge clk);
      trig_fall_p = 1'b0;
   endtask

   task automatic check_quiet(int n, string req);
      repeat (n) begin
         @(negedge clk);
         #1;
         chk(!pulse_o && !err_p && !pulse_rise_p, req, "quiet outputs",
             {pulse_o, err_p, pulse_rise_p}, 0);
      end
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int s, s2, k;
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(!pulse_o && !pulse_rise_p && !pulse_fall_p && !err_p, "R1", "outputs in reset",
          {pulse_o, pulse_rise_p, pulse_fall_p, err_p}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R8: direct single pulse
      s = cyc + 2;
      expect_pulse(s, 1, "R2");
      tset(s, 1'b1);
      #1;
      chk(pulse_o, "R2", "same-cycle pulse", pulse_o, 1);
      tset(s + 3, 1'b0);
      goto_cyc(s + PER + 4);

      // R7: rejected arrivals, early and on the last guard edge
      s = cyc + 2;
      expect_pulse(s, 1, "R2");
      tset(s, 1'b1);
      tset(s + 3, 1'b0);
      expect_ev(s + 4, K_ERR, "R7");
      tset(s + 4, 1'b1);
      tset(s + 5, 1'b0);
      expect_ev(s + PER - 1, K_ERR, "R7");
      tset(s + PER - 1, 1'b1);
      tset(s + PER, 1'b0);
      goto_cyc(s + PER + 4);

      // R6: accepted exactly when the guard window ends
      s = cyc + 2;
      expect_pulse(s, 1, "R2");
      tset(s, 1'b1);
      tset(s + 3, 1'b0);
      s2 = s + PER;
      expect_pulse(s2, 1, "R6");
      tset(s2, 1'b1);
      tset(s2 + 2, 1'b0);
      goto_cyc(s2 + PER + 4);

      // R11: trigger held high across two periods gives one pulse
      s = cyc + 2;
      expect_pulse(s, 1, "R11");
      tset(s, 1'b1);
      tset(s + 2 * PER + 3, 1'b0);
      goto_cyc(s + 2 * PER + 6);

      // R12: strobe inputs ignored on the direct path
      rs_at(cyc + 2);
      fs_at(cyc + 3);
      check_quiet(LAT + 2, "R12");

      // R9: enable low on the direct path
      en = 1'b0;
      tset(cyc + 2, 1'b1);
      #1;
      chk(!pulse_o, "R9", "pulse while disabled", pulse_o, 0);
      check_quiet(3, "R9");
      tset(cyc + 2, 1'b0);
      goto_cyc(cyc + 2);
      en = 1'b1;
      filt_en_n = 1'b0;
      goto_cyc(cyc + 3);

      // R4 R12: filtered latency, raw level has no direct effect
      k = cyc + 2;
      s = k + LAT;
      expect_pulse(s, 0, "R4");
      goto_cyc(k - 1);
      trig_a = 1'b1;
      trig_rise_p = 1'b1;
      #1;
      chk(!pulse_o, "R12", "raw trigger in filtered mode", pulse_o, 0);
      @(negedge clk);
      trig_rise_p = 1'b0;
      goto_cyc(s + PW + 2);
      trig_a = 1'b0;
      fs_at(cyc + 2);
      goto_cyc(s + PER + 3);

      // R5: fall strobe on the last cancelling edge
      k = cyc + 2;
      rs_at(k);
      fs_at(k + LAT - 1);
      check_quiet(LAT + PW, "R5");

      // R5: fall strobe one edge later has no effect
      k = cyc + 2;
      s = k + LAT;
      expect_pulse(s, 0, "R5");
      rs_at(k);
      fs_at(k + LAT);
      goto_cyc(s + PER + 3);

      // R6 R7: filtered guard edges
      k = cyc + 2;
      s = k + LAT;
      expect_pulse(s, 0, "R4");
      rs_at(k);
      expect_ev(s + 1, K_ERR, "R7");
      rs_at(s + 1);
      expect_ev(s + PER - 1, K_ERR, "R7");
      rs_at(s + PER - 1);
      s2 = s + PER + LAT;
      expect_pulse(s2, 0, "R6");
      rs_at(s + PER);
      goto_cyc(s2 + PER + 3);

      // R9: enable low on the filtered path
      en = 1'b0;
      rs_at(cyc + 2);
      check_quiet(LAT + 3, "R9");
      en = 1'b1;
      goto_cyc(cyc + 2);

      // R1: reset in mid-pulse, then immediate acceptance
      k = cyc + 2;
      expect_pulse(k + LAT, 0, "R4");
      rs_at(k);
      goto_cyc(k + LAT + 2);
      rst_n = 1'b0;
      #1;
      chk(!pulse_o && !pulse_rise_p && !pulse_fall_p && !err_p, "R1", "outputs forced low",
          {pulse_o, pulse_rise_p, pulse_fall_p, err_p}, 0);
      exq.delete();
      filt_en_n = 1'b1;
      goto_cyc(cyc + 3);
      rst_n = 1'b1;
      s = cyc + 2;
      expect_pulse(s, 1, "R1");
      tset(s, 1'b1);
      tset(s + 2, 1'b0);
      goto_cyc(s + PER + 3);

      chk(exq.size() == 0, "R3", "pending expectations", exq.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule